// File: doc/BRIEF.md
# DAC Self-Calibration Sequencer

This block runs the digital side of a self-calibrating segmented DAC. A low pulse on the calibrate input starts a run. The run first trims the unipolar offset or the bipolar zero, depending on how the output stage is strapped. It then measures and corrects the carry error at every one of the 64 transitions of the six most significant code bits. Each measurement is a successive-approximation search that steers a trim DAC while watching a single analog comparator. For every segment the search first captures an extrapolated target on a transfer-standard DAC, using an extra LSB. It then matches that target with the correction DAC at the next segment code. The correction code is stored in a 64-entry table addressed by the segment number.

While a run is in progress, the block takes over the main DAC code from the second-rank latch, holds the done flag low and keeps the output multiplexer on the external hold input. At the end it reloads the second-rank latch from the first-rank register and waits a settle interval. It then raises the done flag and, one cycle later, switches the multiplexer to the DAC output. In normal operation the top six bits of the DAC code select the stored word that drives the correction DAC. A supply-fault input throws the block back to the uncalibrated state. A status query on the high-byte-enable input shows whether a run is in progress. The comparator and all analog parts are outside the block.

Top module: `dac_cal_sequencer`

## Requirements
- R1: A falling edge on `calN` (high in one cycle, low in the next) starts a run. From the next cycle until the run completes, `calDone` is low (with `hbeN` high) and `muxSelDac` is 0, so the hold input is selected.
- R2: The run begins with a zero step. `mainCode` is 0 when `bipolarSel` is 0 and 2^(CODE_W-1) when it is 1, `extraLsb` is 0 and `corrCode` is 0. The search steers `offsetTrim`, which keeps its result afterwards.
- R3: Each search tries bits from MSB to LSB. A trial bit is set, held for SETTLE_CYC cycles, and then kept only if `cmpHigh` is 0. The result is the largest trim code for which the comparator reads low: 0 when the target is 0, and all ones when the target is at or above full scale.
- R4: For segment k, taken in order from 0 to 63, the transfer step drives `mainCode` = k*2^(CODE_W-6)-1 (0 for k=0) with `extraLsb`=1, and searches on `xferCode`.
- R5: The correction step then drives `extraLsb`=0 and `mainCode` = k*2^(CODE_W-6), holds `xferCode`, searches on `corrCode`, and stores the result in table entry k.
- R6: After segment 63, the second-rank latch is loaded from `firstRank` and `mainCode` shows it. SETTLE_CYC cycles later `calDone` rises, and `muxSelDac` rises one cycle after that.
- R7: Outside a run, the second-rank latch takes `firstRank` on every clock edge at which `loadDac` is high, and holds while it is low. During a run `loadDac` has no effect.
- R8: Outside a run, when calibrated, `corrCode` is the table entry selected by `mainCode[CODE_W-1 -: 6]`. When uncalibrated, `corrCode` is 0.
- R9: Reset, or `powerFail` high at a clock edge, aborts any run and leaves the block uncalibrated: `calDone` low and `muxSelDac` 0. It stays so until a complete run.
- R10: With `hbeN` low, `calDone` is high while a run is in progress or the block is calibrated, and low when it is uncalibrated and idle.
- R11: A calibrate pulse during a run restarts the sequence at the zero step and re-reads `bipolarSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calN | input | 1 | Calibrate request, active-low pulse |
| powerFail | input | 1 | Supply-fault indication, forces uncalibrated state |
| hbeN | input | 1 | High-byte enable; low turns `calDone` into a status query |
| bipolarSel | input | 1 | Output stage strapping: 1 bipolar, 0 unipolar |
| loadDac | input | 1 | Second-rank latch load, level sensitive |
| firstRank | input | CODE_W | First-rank register contents |
| cmpHigh | input | 1 | Comparator: 1 when the trimmed output is above the target |
| mainCode | output | CODE_W | Code to the main DAC |
| extraLsb | output | 1 | Extra-LSB enable of the main DAC |
| xferCode | output | TRIM_W | Transfer-standard DAC code |
| corrCode | output | TRIM_W | Correction DAC code |
| offsetTrim | output | TRIM_W | Offset / zero trim DAC code |
| calDone | output | 1 | Calibration-done flag (status when `hbeN` low) |
| muxSelDac | output | 1 | Output multiplexer: 1 DAC output, 0 hold input |

## Verification
The bench models the comparator from the block's own outputs. The expected targets depend on the main code and the extra LSB. A sequencer that drives the wrong segment code, forgets to hold the transfer code, or writes to the wrong table entry therefore produces wrong stored words, which show up in the correction code during normal operation. Zero targets at both extremes (0 and full scale) catch a search that mishandles its first or last bit. A restart after the strapping input is flipped partway through a run proves that the zero step is repeated; a design that ignores the pulse ends with the old trim. A supply fault mid-run and after calibration shows whether the block wrongly resumes or keeps its flags. Sampling every cycle at the end of a run catches the multiplexer switching before, or together with, the done flag.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;

  typedef enum logic [1:0] {
    PH_NORMAL = 2'd0,
    PH_ZERO   = 2'd1,
    PH_XFER   = 2'd2,
    PH_CORR   = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_ZERO = 2'd1,
    TG_XFER = 2'd2,
    TG_CORR = 2'd3
  } target_t;

  typedef struct packed {
    phase_t  phase;
    target_t tgt;
    logic    sarStart;
    logic    sarStep;
    logic    timerClr;
    logic    ramWrite;
    logic    segClr;
    logic    segInc;
    logic    reload;
    logic    corrFromRam;
  } ctrl_strobe_t;

endpackage

// File: rtl/dcal_datapath.sv
module dcal_datapath
  import dac_cal_pkg::*;
#(
  parameter int CODE_W     = 16,
  parameter int SEG_W      = 6,
  parameter int TRIM_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        st,
  input  logic                running,
  input  logic                cmpHigh,
  input  logic                bipolarSel,
  input  logic                loadDac,
  input  logic [CODE_W-1:0]   firstRank,
  output logic [CODE_W-1:0]   mainCode,
  output logic                extraLsb,
  output logic [TRIM_W-1:0]   xferCode,
  output logic [TRIM_W-1:0]   corrCode,
  output logic [TRIM_W-1:0]   offsetTrim,
  output logic                timerDone,
  output logic                sarLast,
  output logic                segLast
);

  localparam int LOW_W = CODE_W - SEG_W;
  localparam int DEPTH = 1 << SEG_W;
  localparam int TMR_W = $clog2(SETTLE_CYC + 1);
  localparam logic [TRIM_W-1:0] TOP_BIT = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [TRIM_W-1:0] sarMask, offReg, xferReg, corrReg;
  logic [SEG_W-1:0]  segIdx;
  logic [TMR_W-1:0]  timer;
  logic [CODE_W-1:0] dacLatch;
  logic [CODE_W-1:0] segBase;
  logic [TRIM_W-1:0] ram [DEPTH];

  // Drop the trial bit when the comparator reads high, then try the next one.
  function automatic logic [TRIM_W-1:0] sarNext(input logic [TRIM_W-1:0] cur,
                                                input logic [TRIM_W-1:0] mask,
                                                input logic hi);
    logic [TRIM_W-1:0] v;
    v = cur;
    if (hi) v = v & ~mask;
    v = v | (mask >> 1);
    return v;
  endfunction

  // Settle timer, saturating at its terminal count.
  assign timerDone = (timer == TMR_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (st.sarStart || st.sarStep || st.timerClr) begin
      timer <= '0;
    end else if (!timerDone) begin
      timer <= timer + TMR_W'(1);
    end
  end

  // Successive-approximation registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarMask <= '0;
      offReg  <= '0;
      xferReg <= '0;
      corrReg <= '0;
    end else if (st.sarStart) begin
      sarMask <= TOP_BIT;
      case (st.tgt)
        TG_ZERO: offReg  <= TOP_BIT;
        TG_XFER: xferReg <= TOP_BIT;
        TG_CORR: corrReg <= TOP_BIT;
        default: ;
      endcase
    end else if (st.sarStep) begin
      sarMask <= sarMask >> 1;
      case (st.tgt)
        TG_ZERO: offReg  <= sarNext(offReg, sarMask, cmpHigh);
        TG_XFER: xferReg <= sarNext(xferReg, sarMask, cmpHigh);
        TG_CORR: corrReg <= sarNext(corrReg, sarMask, cmpHigh);
        default: ;
      endcase
    end
  end

  assign sarLast = sarMask[0];

  // Segment counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segIdx <= '0;
    end else if (st.segClr) begin
      segIdx <= '0;
    end else if (st.segInc) begin
      segIdx <= segIdx + SEG_W'(1);
    end
  end

  assign segLast = &segIdx;

  // Correction table.
  always_ff @(posedge clk) begin
    if (st.ramWrite) ram[segIdx] <= corrReg;
  end

  // Second-rank latch: overridden while a run is in progress.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacLatch <= '0;
    end else if (st.reload || (loadDac && !running)) begin
      dacLatch <= firstRank;
    end
  end

  assign segBase = {segIdx, {LOW_W{1'b0}}};

  always_comb begin
    case (st.phase)
      PH_ZERO: mainCode = bipolarSel ? MID_CODE : '0;
      PH_XFER: mainCode = (segIdx == '0) ? '0 : segBase - CODE_W'(1);
      PH_CORR: mainCode = segBase;
      default: mainCode = dacLatch;
    endcase
  end

  always_comb begin
    if (st.phase == PH_CORR)  corrCode = corrReg;
    else if (st.corrFromRam)  corrCode = ram[dacLatch[CODE_W-1 -: SEG_W]];
    else                      corrCode = '0;
  end

  assign extraLsb   = (st.phase == PH_XFER);
  assign xferCode   = xferReg;
  assign offsetTrim = offReg;

endmodule

// File: rtl/dcal_ctrl.sv
module dcal_ctrl
  import dac_cal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         calN,
  input  logic         powerFail,
  input  logic         hbeN,
  input  logic         timerDone,
  input  logic         sarLast,
  input  logic         segLast,
  output ctrl_strobe_t st,
  output logic         running,
  output logic         calDone,
  output logic         muxSelDac
);

  typedef enum logic [2:0] {
    S_IDLE, S_ZERO, S_XFER, S_CORR, S_WRITE, S_RELOAD, S_SETTLE, S_MUX
  } state_t;

  state_t state, nState;
  logic   armed, nArmed;
  logic   doneReg, muxReg, calPrev;
  logic   start;

  assign start = calPrev && !calN;

  always_comb begin
    st             = '0;
    st.phase       = PH_NORMAL;
    st.tgt         = TG_NONE;
    st.corrFromRam = doneReg;
    nState         = state;
    nArmed         = armed;

    case (state)
      S_ZERO, S_XFER, S_CORR: begin
        case (state)
          S_ZERO:  begin st.phase = PH_ZERO; st.tgt = TG_ZERO; end
          S_XFER:  begin st.phase = PH_XFER; st.tgt = TG_XFER; end
          default: begin st.phase = PH_CORR; st.tgt = TG_CORR; end
        endcase
        if (!armed) begin
          st.sarStart = 1'b1;
          nArmed      = 1'b1;
        end else if (timerDone) begin
          st.sarStep = 1'b1;
          if (sarLast) begin
            nArmed = 1'b0;
            case (state)
              S_ZERO:  nState = S_XFER;
              S_XFER:  nState = S_CORR;
              default: nState = S_WRITE;
            endcase
          end
        end
      end
      S_WRITE: begin
        st.phase    = PH_CORR;
        st.ramWrite = 1'b1;
        if (segLast) begin
          nState = S_RELOAD;
        end else begin
          st.segInc = 1'b1;
          nState    = S_XFER;
        end
      end
      S_RELOAD: begin
        st.reload   = 1'b1;
        st.timerClr = 1'b1;
        nState      = S_SETTLE;
      end
      S_SETTLE: if (timerDone) nState = S_MUX;
      S_MUX:    nState = S_IDLE;
      default:  ;
    endcase

    if (start) begin
      st        = '0;
      st.phase  = PH_NORMAL;
      st.tgt    = TG_NONE;
      st.segClr = 1'b1;
      nState    = S_ZERO;
      nArmed    = 1'b0;
    end

    if (powerFail) begin
      st       = '0;
      st.phase = PH_NORMAL;
      st.tgt   = TG_NONE;
      nState   = S_IDLE;
      nArmed   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      armed   <= 1'b0;
      running <= 1'b0;
      doneReg <= 1'b0;
      muxReg  <= 1'b0;
      calPrev <= 1'b1;
    end else begin
      calPrev <= calN;
      state   <= nState;
      armed   <= nArmed;
      if (powerFail) begin
        running <= 1'b0;
        doneReg <= 1'b0;
        muxReg  <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        doneReg <= 1'b0;
        muxReg  <= 1'b0;
      end else if (state == S_SETTLE && timerDone) begin
        running <= 1'b0;
        doneReg <= 1'b1;
      end else if (state == S_MUX) begin
        muxReg <= 1'b1;
      end
    end
  end

  // Status query: with hbeN low the flag reports activity or a valid calibration.
  assign calDone   = hbeN ? doneReg : (running || doneReg);
  assign muxSelDac = muxReg;

endmodule

// File: rtl/dac_cal_sequencer.sv
module dac_cal_sequencer
  import dac_cal_pkg::*;
#(
  parameter int CODE_W     = 16,
  parameter int SEG_W      = 6,
  parameter int TRIM_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calN,
  input  logic              powerFail,
  input  logic              hbeN,
  input  logic              bipolarSel,
  input  logic              loadDac,
  input  logic [CODE_W-1:0] firstRank,
  input  logic              cmpHigh,
  output logic [CODE_W-1:0] mainCode,
  output logic              extraLsb,
  output logic [TRIM_W-1:0] xferCode,
  output logic [TRIM_W-1:0] corrCode,
  output logic [TRIM_W-1:0] offsetTrim,
  output logic              calDone,
  output logic              muxSelDac
);

  ctrl_strobe_t st;
  logic running, timerDone, sarLast, segLast;

  dcal_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .calN      (calN),
    .powerFail (powerFail),
    .hbeN      (hbeN),
    .timerDone (timerDone),
    .sarLast   (sarLast),
    .segLast   (segLast),
    .st        (st),
    .running   (running),
    .calDone   (calDone),
    .muxSelDac (muxSelDac)
  );

  dcal_datapath #(
    .CODE_W     (CODE_W),
    .SEG_W      (SEG_W),
    .TRIM_W     (TRIM_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .running    (running),
    .cmpHigh    (cmpHigh),
    .bipolarSel (bipolarSel),
    .loadDac    (loadDac),
    .firstRank  (firstRank),
    .mainCode   (mainCode),
    .extraLsb   (extraLsb),
    .xferCode   (xferCode),
    .corrCode   (corrCode),
    .offsetTrim (offsetTrim),
    .timerDone  (timerDone),
    .sarLast    (sarLast),
    .segLast    (segLast)
  );

endmodule

// File: rtl/dac_cal_sequencer_chk.sv
module dac_cal_sequencer_chk #(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              hbeN,
  input logic              powerFail,
  input logic              loadDac,
  input logic              extraLsb,
  input logic [CODE_W-1:0] mainCode,
  input logic              calDone,
  input logic              muxSelDac
);

  localparam int LOW_W = CODE_W - SEG_W;

  // R4: the transfer step always sits one code below a segment boundary
  p_xfer_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    extraLsb |-> ((mainCode == '0) || (&mainCode[LOW_W-1:0])));

  // R1: while the sequencer drives the DAC, the hold input is selected and done is low
  p_run_flags_r1: assert property (@(posedge clk) disable iff (!rstN)
    extraLsb |-> (!muxSelDac && !(hbeN && calDone)));

  // R10: status query reports an active run
  p_status_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!hbeN && extraLsb) |-> calDone);

  // R6: the DAC output is only selected once done is set
  p_mux_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hbeN && muxSelDac) |-> calDone);

  // R9: a supply fault clears both flags by the next cycle
  p_pfail_r9: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> (!calDone && !muxSelDac));

  // R7: calibrated and idle, the code moves only after a load
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (muxSelDac && $past(muxSelDac) && !$past(loadDac)) |-> $stable(mainCode));

endmodule

bind dac_cal_sequencer dac_cal_sequencer_chk #(
  .CODE_W (CODE_W),
  .SEG_W  (SEG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hbeN      (hbeN),
  .powerFail (powerFail),
  .loadDac   (loadDac),
  .extraLsb  (extraLsb),
  .mainCode  (mainCode),
  .calDone   (calDone),
  .muxSelDac (muxSelDac)
);

// File: tb/tb_dac_cal_sequencer.sv
`timescale 1ns/1ps
module tb_dac_cal_sequencer;

  localparam int CODE_W = 16;
  localparam int SEG_W  = 6;
  localparam int TRIM_W = 8;
  localparam int LOW_W  = CODE_W - SEG_W;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN, calN, powerFail, hbeN, bipolarSel, loadDac, cmpHigh;
  logic [CODE_W-1:0] firstRank, mainCode;
  logic extraLsb, calDone, muxSelDac;
  logic [TRIM_W-1:0] xferCode, corrCode, offsetTrim;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dac_cal_sequencer #(.CODE_W(CODE_W), .SEG_W(SEG_W), .TRIM_W(TRIM_W), .SETTLE_CYC(4)) dut (
    .clk(clk), .rstN(rstN), .calN(calN), .powerFail(powerFail), .hbeN(hbeN),
    .bipolarSel(bipolarSel), .loadDac(loadDac), .firstRank(firstRank), .cmpHigh(cmpHigh),
    .mainCode(mainCode), .extraLsb(extraLsb), .xferCode(xferCode), .corrCode(corrCode),
    .offsetTrim(offsetTrim), .calDone(calDone), .muxSelDac(muxSelDac)
  );

  // Analog model targets
  function automatic int xferTarget(int s);
    return ((s * 29 + 40) % 200) + 20;
  endfunction
  function automatic int carryErr(int s);
    return (s * 7) % 23;
  endfunction
  function automatic int expCorr(int s);
    return xferTarget(s) + carryErr(s);
  endfunction
  function automatic int zeroTarget(int m);
    if (m == 0) return 0;
    if (m == 32768) return 255;
    return 128;
  endfunction

  always_comb begin
    if (extraLsb)
      cmpHigh = int'(xferCode) > xferTarget((int'(mainCode) + 1) >> LOW_W);
    else if (corrCode != '0)
      cmpHigh = int'(corrCode) > (int'(xferCode) + carryErr(int'(mainCode) >> LOW_W));
    else
      cmpHigh = int'(offsetTrim) > zeroTarget(int'(mainCode));
  end

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseCal();
    calN = 1'b0;
    @(negedge clk);
    calN = 1'b1;
  endtask

  // Waits for the end of a run; checks done-then-mux ordering (R6).
  task automatic waitDone();
    bit prevDone = calDone;
    bit prevMux  = muxSelDac;
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (muxSelDac && !prevMux) begin
        seen = 1;
        check(prevDone && calDone, "R6 done high one cycle before mux", int'(prevDone), 1);
      end
      prevDone = calDone;
      prevMux  = muxSelDac;
    end
    check(seen, "R6 run completes", int'(seen), 1);
  endtask

  task automatic checkTable(input string tag);
    int codes[4] = '{16'h0000, 16'h03FF, 16'h8000, 16'hFC00};
    foreach (codes[i]) begin
      firstRank = CODE_W'(codes[i]);
      loadDac = 1'b1;
      @(negedge clk);
      loadDac = 1'b0;
      @(negedge clk);
      check(corrCode == TRIM_W'(expCorr(codes[i] >> LOW_W)), tag,
            int'(corrCode), expCorr(codes[i] >> LOW_W));
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; calN = 1'b1; powerFail = 1'b0; hbeN = 1'b1;
    bipolarSel = 1'b0; loadDac = 1'b0; firstRank = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!calDone && !muxSelDac, "R9 reset uncalibrated", int'({calDone, muxSelDac}), 0);
    check(corrCode == '0 && mainCode == '0 && !extraLsb, "R9 reset outputs",
          int'(corrCode), 0);
  endtask

  task automatic testLatch();
    firstRank = 16'h1234; loadDac = 1'b1;
    @(negedge clk);
    check(mainCode == 16'h1234, "R7 latch transparent", int'(mainCode), 16'h1234);
    loadDac = 1'b0; firstRank = 16'h5555;
    @(negedge clk); @(negedge clk);
    check(mainCode == 16'h1234, "R7 latch holds with load low", int'(mainCode), 16'h1234);
    check(corrCode == '0, "R8 uncalibrated correction zero", int'(corrCode), 0);
  endtask

  task automatic testUnipolar();
    firstRank = 16'hABCD;
    bipolarSel = 1'b0;
    pulseCal();
    repeat (3) @(negedge clk);
    check(!calDone && !muxSelDac, "R1 flags low during run", int'({calDone, muxSelDac}), 0);
    hbeN = 1'b0;
    @(negedge clk);
    check(calDone, "R10 status shows run in progress", int'(calDone), 1);
    hbeN = 1'b1;
    // R7: load request ignored while running
    loadDac = 1'b1; firstRank = 16'hABCD;
    waitDone();
    loadDac = 1'b0;
    check(mainCode == 16'hABCD, "R6 latch reloaded from first rank", int'(mainCode), 16'hABCD);
    check(offsetTrim == 8'd0, "R2 R3 unipolar zero trim at floor", int'(offsetTrim), 0);
    check(xferCode == TRIM_W'(xferTarget(63)), "R4 last transfer code", int'(xferCode),
          xferTarget(63));
    check(corrCode == TRIM_W'(expCorr(16'hABCD >> LOW_W)), "R5 R8 correction at reloaded code",
          int'(corrCode), expCorr(16'hABCD >> LOW_W));
    checkTable("R5 R8 table entry");
    hbeN = 1'b0;
    @(negedge clk);
    check(calDone, "R10 status when calibrated", int'(calDone), 1);
    hbeN = 1'b1;
  endtask

  task automatic testRestart();
    bit seenXfer = 0;
    bipolarSel = 1'b0;
    pulseCal();
    for (int i = 0; i < 2000 && !seenXfer; i++) begin
      @(negedge clk);
      if (extraLsb) seenXfer = 1;
    end
    check(seenXfer, "R4 transfer step reached", int'(seenXfer), 1);
    bipolarSel = 1'b1;
    pulseCal();
    @(negedge clk);
    check(!extraLsb && mainCode == 16'h8000, "R11 R2 restart at bipolar zero step",
          int'(mainCode), 16'h8000);
    waitDone();
    check(offsetTrim == 8'd255, "R11 R3 bipolar zero trim at full scale", int'(offsetTrim), 255);
    checkTable("R5 table after restart");
  endtask

  task automatic testPowerFailRun();
    pulseCal();
    repeat (200) @(negedge clk);
    powerFail = 1'b1;
    @(negedge clk);
    powerFail = 1'b0;
    check(!calDone && !muxSelDac, "R9 fault aborts run", int'({calDone, muxSelDac}), 0);
    repeat (300) @(negedge clk);
    check(!muxSelDac && !extraLsb, "R9 no resume after fault", int'(muxSelDac), 0);
    hbeN = 1'b0;
    @(negedge clk);
    check(!calDone, "R10 status low when uncalibrated", int'(calDone), 0);
    hbeN = 1'b1;
    firstRank = 16'h8000; loadDac = 1'b1;
    @(negedge clk);
    loadDac = 1'b0;
    @(negedge clk);
    check(corrCode == '0, "R8 R9 no correction after fault", int'(corrCode), 0);
  endtask

  task automatic testPowerFailIdle();
    bipolarSel = 1'b0;
    pulseCal();
    waitDone();
    check(calDone && muxSelDac, "R6 calibrated before fault", int'({calDone, muxSelDac}), 3);
    powerFail = 1'b1;
    @(negedge clk);
    powerFail = 1'b0;
    @(negedge clk);
    check(!calDone && !muxSelDac && corrCode == '0, "R9 fault clears calibration",
          int'({calDone, muxSelDac}), 0);
  endtask

  initial begin
    doReset();
    testLatch();
    testUnipolar();
    testRestart();
    testPowerFailRun();
    testPowerFailIdle();
    summary();
    $finish;
  end

endmodule